// File: doc/BRIEF.md
# Dual-Width Add-With-Carry Flag Unit

This block is the arithmetic and condition-flag stage of an integer datapath. It adds two 64-bit operands and a carry-in to form a result. It also forms the four condition flags: negative (N), zero (Z), carry (C) and overflow (V). A width-select input chooses the flag position: in the narrow mode the flags come from bit 31, and in the wide mode they come from bit 63. In the narrow mode the result is zero above bit 31, and the upper operand bits have no effect.

Several operations share the one adder:
- Subtraction is formed by inverting the second operand and forcing the carry-in to one.
- The carry-chaining forms (add-with-carry and subtract-with-carry) take their carry-in from the stored C flag.
- A conditional compare either loads the flags from a compare or a compare-negative, or, when an externally evaluated condition has failed, loads a 4-bit immediate.
- Two bitwise operations (AND and XOR) set N and Z from their result and clear C and V.

The flags are held in a register. It loads on a clock edge only when the set-flags input is high or a compare operation is presented. A synchronous reset clears it.

Top module: `awc_flag_unit`

## Requirements
- R1: With `wide`=1, `op_sel`=0 (add) drives `result` with (op_a + op_b) mod 2^64, and C is the carry out of bit 63. `flags_q` packs the flags as {N,Z,C,V} from bit 3 down to bit 0.
- R2: With `wide`=0, `result[63:32]` is zero, `result[31:0]` depends only on the low 32 bits of both operands, and C is the carry out of bit 31.
- R3: N equals the top bit of the selected width of `result`. Z is 1 exactly when the width-masked `result` is zero.
- R4: V is 1 when the two adder inputs (after any inversion) share a sign bit at the selected width and the result sign differs from it.
- R5: `op_sel`=1 (subtract) computes op_a + ~op_b + 1, so C=1 means no borrow.
- R6: `op_sel`=2 (add with carry) and `op_sel`=3 (subtract with carry, op_a + ~op_b + C) use the stored C flag from `flags_q[1]` as carry-in.
- R7: `op_sel`=4 (compare-negative, op_a + op_b + 0) and `op_sel`=5 (compare, op_a + ~op_b + 1) with `cond_pass`=1 load the adder flags into `flags_q`, even when `set_flags`=0.
- R8: For `op_sel` 4 or 5 with `cond_pass`=0, `flags_q` loads `nzcv_imm` on the next edge. For all other operations `cond_pass` and `nzcv_imm` have no effect.
- R9: `op_sel`=6 (AND) and `op_sel`=7 (XOR) drive the bitwise result, masked to the selected width. They set N and Z from that result and clear C and V.
- R10: For `op_sel` 0 to 3 and 6 to 7 with `set_flags`=0, `flags_q` keeps its value, while `result` is still produced.
- R11: `rst` high at a clock edge clears `flags_q` to 0000, synchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_sel | input | 3 | Operation code (0 add, 1 sub, 2 adc, 3 sbc, 4 cmn, 5 cmp, 6 and, 7 xor) |
| wide | input | 1 | 1 selects 64-bit mode, 0 selects 32-bit mode |
| set_flags | input | 1 | Load adder or logic flags on the next edge |
| cond_pass | input | 1 | Externally evaluated condition for compare operations |
| nzcv_imm | input | 4 | Flags loaded when a compare's condition fails |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| result | output | 64 | Combinational result, zero above bit 31 in narrow mode |
| flags_q | output | 4 | Registered flags {N,Z,C,V} |

## Verification
The hardest states to reach from the ports are the carry-chaining forms. Their outcome depends on a C flag left behind by an earlier operation, so the bench first runs an add that overflows to leave C=1, then runs add-with-carry and subtract-with-carry back to back so each one sees the carry left by the one before. Narrow mode is driven with non-zero upper operand bits, chosen so that a wide-mode result or flag would differ visibly. Failed compares are paired with a non-compare operation that presents a failing condition and an all-ones immediate, so a leak of the immediate into the flag register would be visible.

// File: rtl/awc_pkg.sv
package awc_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_ADC = 3'd2,
    OP_SBC = 3'd3,
    OP_CMN = 3'd4,
    OP_CMP = 3'd5,
    OP_AND = 3'd6,
    OP_EOR = 3'd7
  } awc_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  function automatic logic op_is_compare(awc_op_e op);
    return (op == OP_CMN) || (op == OP_CMP);
  endfunction

  function automatic logic op_is_logic(awc_op_e op);
    return (op == OP_AND) || (op == OP_EOR);
  endfunction

  function automatic logic op_inverts_b(awc_op_e op);
    return (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
  endfunction

  // carry-in choice: fixed 0, fixed 1, or the stored carry flag
  function automatic logic op_carry_in(awc_op_e op, logic stored_c);
    logic cin;
    case (op)
      OP_SUB, OP_CMP: cin = 1'b1;
      OP_ADC, OP_SBC: cin = stored_c;
      default:        cin = 1'b0;
    endcase
    return cin;
  endfunction

endpackage

// File: rtl/awc_operand_prep.sv
module awc_operand_prep
  import awc_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  awc_op_e           op,
  input  logic [DATA_W-1:0] b_in,
  input  logic              stored_c,
  output logic [DATA_W-1:0] b_eff,
  output logic              cin
);

  always_comb begin
    b_eff = op_inverts_b(op) ? ~b_in : b_in;
    cin   = op_carry_in(op, stored_c);
  end

endmodule

// File: rtl/awc_adder_core.sv
module awc_adder_core
  import awc_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  input  logic              wide,
  output logic [DATA_W-1:0] sum,
  output nzcv_t             flags
);

  localparam int PAD_W = DATA_W - NARROW_W;

  logic [DATA_W:0]   full_sum;
  logic [NARROW_W:0] nar_sum;
  logic              sign_a;
  logic              sign_b;

  always_comb begin
    full_sum = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
    nar_sum  = {1'b0, a[NARROW_W-1:0]} + {1'b0, b[NARROW_W-1:0]}
             + {{NARROW_W{1'b0}}, cin};
    if (wide) begin
      sum     = full_sum[DATA_W-1:0];
      flags.c = full_sum[DATA_W];
      flags.n = full_sum[DATA_W-1];
      sign_a  = a[DATA_W-1];
      sign_b  = b[DATA_W-1];
    end else begin
      sum     = {{PAD_W{1'b0}}, nar_sum[NARROW_W-1:0]};
      flags.c = nar_sum[NARROW_W];
      flags.n = nar_sum[NARROW_W-1];
      sign_a  = a[NARROW_W-1];
      sign_b  = b[NARROW_W-1];
    end
    flags.z = (sum == '0);
    flags.v = (sign_a == sign_b) && (flags.n != sign_a);
  end

endmodule

// File: rtl/awc_logic_unit.sv
module awc_logic_unit
  import awc_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32
) (
  input  awc_op_e           op,
  input  logic              wide,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res,
  output nzcv_t             flags
);

  localparam int PAD_W = DATA_W - NARROW_W;

  logic [DATA_W-1:0] raw;

  always_comb begin
    raw     = (op == OP_AND) ? (a & b) : (a ^ b);
    res     = wide ? raw : {{PAD_W{1'b0}}, raw[NARROW_W-1:0]};
    flags.n = wide ? res[DATA_W-1] : res[NARROW_W-1];
    flags.z = (res == '0);
    flags.c = 1'b0;
    flags.v = 1'b0;
  end

endmodule

// File: rtl/awc_flag_reg.sv
module awc_flag_reg
  import awc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load,
  input  nzcv_t d,
  output nzcv_t q
);

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

endmodule

// File: rtl/awc_flag_unit.sv
module awc_flag_unit
  import awc_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        op_sel,
  input  logic              wide,
  input  logic              set_flags,
  input  logic              cond_pass,
  input  logic [3:0]        nzcv_imm,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        flags_q
);

  awc_op_e           op;
  logic [DATA_W-1:0] b_eff;
  logic              cin;
  logic [DATA_W-1:0] add_sum;
  nzcv_t             add_flags;
  logic [DATA_W-1:0] log_res;
  nzcv_t             log_flags;
  nzcv_t             res_flags;
  nzcv_t             flag_d;
  nzcv_t             flag_q_s;
  logic              flag_load;
  logic              take_imm;

  assign op = awc_op_e'(op_sel);

  awc_operand_prep #(.DATA_W(DATA_W)) u_prep (
    .op       (op),
    .b_in     (op_b),
    .stored_c (flag_q_s.c),
    .b_eff    (b_eff),
    .cin      (cin)
  );

  awc_adder_core #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_add (
    .a     (op_a),
    .b     (b_eff),
    .cin   (cin),
    .wide  (wide),
    .sum   (add_sum),
    .flags (add_flags)
  );

  awc_logic_unit #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_log (
    .op    (op),
    .wide  (wide),
    .a     (op_a),
    .b     (op_b),
    .res   (log_res),
    .flags (log_flags)
  );

  always_comb begin
    result    = op_is_logic(op) ? log_res : add_sum;
    res_flags = op_is_logic(op) ? log_flags : add_flags;
    take_imm  = op_is_compare(op) && !cond_pass;
    flag_load = op_is_compare(op) || set_flags;
    flag_d    = take_imm ? nzcv_t'(nzcv_imm) : res_flags;
  end

  awc_flag_reg u_flags (
    .clk  (clk),
    .rst  (rst),
    .load (flag_load),
    .d    (flag_d),
    .q    (flag_q_s)
  );

  assign flags_q = flag_q_s;

endmodule

// File: rtl/awc_flag_unit_chk.sv
module awc_flag_unit_chk #(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        op_sel,
  input logic              wide,
  input logic              set_flags,
  input logic              cond_pass,
  input logic [3:0]        nzcv_imm,
  input logic [DATA_W-1:0] result,
  input logic [3:0]        flags_q,
  input logic [3:0]        res_flags
);

  logic is_cmp;
  logic is_log;
  assign is_cmp = (op_sel[2:1] == 2'b10);
  assign is_log = (op_sel[2:1] == 2'b11);

  a_r2_narrow_upper_zero: assert property (@(posedge clk) disable iff (rst)
    !wide |-> (result[DATA_W-1:NARROW_W] == '0));

  a_r3_zero_flag: assert property (@(posedge clk) disable iff (rst)
    res_flags[2] == (result == '0));

  a_r7_compare_loads: assert property (@(posedge clk) disable iff (rst)
    (is_cmp && cond_pass) |=> (flags_q == $past(res_flags)));

  a_r8_imm_on_fail: assert property (@(posedge clk) disable iff (rst)
    (is_cmp && !cond_pass) |=> (flags_q == $past(nzcv_imm)));

  a_r9_logic_clears_cv: assert property (@(posedge clk) disable iff (rst)
    (is_log && set_flags) |=> (flags_q[1:0] == 2'b00));

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (!is_cmp && !set_flags) |=> $stable(flags_q));

  a_r11_reset: assert property (@(posedge clk)
    rst |=> (flags_q == 4'b0000));

endmodule

bind awc_flag_unit awc_flag_unit_chk #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .op_sel    (op_sel),
  .wide      (wide),
  .set_flags (set_flags),
  .cond_pass (cond_pass),
  .nzcv_imm  (nzcv_imm),
  .result    (result),
  .flags_q   (flags_q),
  .res_flags (res_flags)
);

// File: tb/tb_awc_flag_unit.sv
module tb_awc_flag_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op_sel = '0;
  logic        wide = 1'b1;
  logic        set_flags = 1'b0;
  logic        cond_pass = 1'b1;
  logic [3:0]  nzcv_imm = '0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic [63:0] result;
  logic [3:0]  flags_q;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  awc_flag_unit dut (
    .clk(clk), .rst(rst), .op_sel(op_sel), .wide(wide), .set_flags(set_flags),
    .cond_pass(cond_pass), .nzcv_imm(nzcv_imm), .op_a(op_a), .op_b(op_b),
    .result(result), .flags_q(flags_q)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  op;
    logic        w;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] res;
    logic [3:0]  f;
  } vec_t;

  // flag nibble is {N,Z,C,V}
  localparam vec_t VECS [14] = '{
    '{4'd1, 3'd0, 1'b1, 64'h1, 64'h2, 64'h3, 4'b0000},                                      // R1
    '{4'd1, 3'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'h0, 4'b0110},                    // R1 R3
    '{4'd4, 3'd0, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 64'h8000_0000_0000_0000, 4'b1001},  // R4
    '{4'd2, 3'd0, 1'b0, 64'hDEAD_BEEF_FFFF_FFFF, 64'h1, 64'h0, 4'b0110},                    // R2
    '{4'd4, 3'd0, 1'b0, 64'h0000_0000_7FFF_FFFF, 64'h1, 64'h0000_0000_8000_0000, 4'b1001},  // R4 R2
    '{4'd3, 3'd0, 1'b0, 64'h1_0000_0000, 64'h0, 64'h0, 4'b0100},                            // R3 R2
    '{4'd5, 3'd1, 1'b1, 64'h5, 64'h3, 64'h2, 4'b0010},                                      // R5
    '{4'd5, 3'd1, 1'b1, 64'h3, 64'h5, 64'hFFFF_FFFF_FFFF_FFFE, 4'b1000},                    // R5
    '{4'd4, 3'd1, 1'b1, 64'h8000_0000_0000_0000, 64'h1, 64'h7FFF_FFFF_FFFF_FFFF, 4'b0011},  // R4 R5
    '{4'd5, 3'd1, 1'b0, 64'h1234_5678_0000_0007, 64'h7, 64'h0, 4'b0110},                    // R5 R2
    '{4'd9, 3'd6, 1'b1, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_0000_0000_0000, 64'hF000_0000_0000_0000, 4'b1000}, // R9
    '{4'd5, 3'd1, 1'b0, 64'h0, 64'h1, 64'h0000_0000_FFFF_FFFF, 4'b1000},                    // R5 R2
    '{4'd9, 3'd7, 1'b0, 64'hAAAA_AAAA_5555_5555, 64'h5555_5555, 64'h0, 4'b0100},            // R9
    '{4'd9, 3'd7, 1'b1, 64'h0, 64'h8000_0000, 64'h0000_0000_8000_0000, 4'b0000}             // R9 R3
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input string req, input logic [2:0] op, input logic w,
                      input logic [63:0] a, input logic [63:0] b, input logic sf,
                      input logic cp, input logic [3:0] imm,
                      input logic [63:0] exp_res, input logic [3:0] exp_f);
    @(negedge clk);
    op_sel = op; wide = w; op_a = a; op_b = b;
    set_flags = sf; cond_pass = cp; nzcv_imm = imm;
    #2;
    chk({req, " result"}, result, exp_res);
    @(posedge clk);
    #1;
    chk({req, " flags"}, {60'h0, flags_q}, {60'h0, exp_f});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R11 reset state", {60'h0, flags_q}, 64'h0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < 14; i++) begin
      step($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].op, VECS[i].w,
           VECS[i].a, VECS[i].b, 1'b1, 1'b1, 4'b0000, VECS[i].res, VECS[i].f);
    end

    // R6 carry chaining from stored C
    step("R6 setup", 3'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b1, 1'b1, 4'h0, 64'h0, 4'b0110);
    step("R6 adc c1", 3'd2, 1'b1, 64'h1, 64'h1, 1'b1, 1'b1, 4'h0, 64'h3, 4'b0000);
    step("R6 adc c0", 3'd2, 1'b1, 64'h1, 64'h1, 1'b1, 1'b1, 4'h0, 64'h2, 4'b0000);
    step("R6 sbc c0", 3'd3, 1'b1, 64'h5, 64'h3, 1'b1, 1'b1, 4'h0, 64'h1, 4'b0010);
    step("R6 sbc c1", 3'd3, 1'b1, 64'h5, 64'h3, 1'b1, 1'b1, 4'h0, 64'h2, 4'b0010);

    // R10 hold with set_flags low
    step("R10 add hold", 3'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b0, 1'b1, 4'h0, 64'h0, 4'b0010);
    step("R10 and hold", 3'd6, 1'b1, 64'hF000_0000_0000_0000, 64'hF000_0000_0000_0000,
         1'b0, 1'b1, 4'h0, 64'hF000_0000_0000_0000, 4'b0010);

    // R7 compares load flags even with set_flags low
    step("R7 cmp eq", 3'd5, 1'b1, 64'h4, 64'h4, 1'b0, 1'b1, 4'hF, 64'h0, 4'b0110);
    step("R7 cmn narrow", 3'd4, 1'b0, 64'hFFFF_FFFF_7FFF_FFFF, 64'h1, 1'b0, 1'b1, 4'h0,
         64'h0000_0000_8000_0000, 4'b1001);

    // R8 failed condition loads the immediate
    step("R8 cmp fail", 3'd5, 1'b1, 64'h4, 64'h4, 1'b0, 1'b0, 4'b1010, 64'h0, 4'b1010);
    step("R8 cmn fail", 3'd4, 1'b1, 64'h1, 64'h1, 1'b1, 1'b0, 4'b0101, 64'h2, 4'b0101);
    step("R8 non-compare ignores imm", 3'd0, 1'b1, 64'h1, 64'h2, 1'b1, 1'b0, 4'b1111, 64'h3, 4'b0000);

    // R11 synchronous reset mid-run
    step("R11 setup", 3'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b1, 1'b1, 4'h0, 64'h0, 4'b0110);
    @(negedge clk);
    set_flags = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk("R11 sync clear", {60'h0, flags_q}, 64'h0);
    @(negedge clk);
    rst = 1'b0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule